// File: doc/BRIEF.md
# Soft Lock Bit Bank

This block keeps a small bank of software-controlled lock registers. Each lock register guards one protected 32-bit word, holding one lock bit per byte lane of that word. A set lock bit means that writes to that byte lane of the protected word must be suppressed. The per-lane lock state is driven straight out on a flat status vector, and the protected peripheral's write path uses it.

Software changes the locks with a single write. The write carries four lock data bits and, in the same word, four write enables. Each protected word has a static access granularity: byte, half-word, full word, or a mixed layout. The granularity decides which enables are honoured and how data from a lower lane is copied into upper lanes. Because of this, a word that is only ever accessed as a whole cannot end up with lanes that disagree. A read returns the stored lock bits. The enables are never stored.

Top module: `slb_bank`

## Requirements
- R1: On an active-low synchronous reset, every lock bit becomes 0 (unlocked).
- R2: Write format: `wr_data[k]` is the lock data for lane k and `wr_data[4+k]` is the write enable for lane k (k = 0..3). A write changes only the register selected by `wr_addr`. Every other register keeps its lock bits.
- R3: Granularity code 00 (byte): lane k takes `wr_data[k]` when its enable `wr_data[4+k]` is 1, and keeps its value otherwise.
- R4: Granularity code 01 (half-word): the enable of lane 0 controls lanes 0 and 1, which both take data bit 0. The enable of lane 2 controls lanes 2 and 3, which both take data bit 2. The enables of lanes 1 and 3 and the data bits of lanes 1 and 3 have no effect. Each half updates independently.
- R5: Granularity code 10 (word): the enable of lane 0 alone controls all four lanes, which all take data bit 0. When that enable is 0, all four lanes keep their values whatever the other enables are.
- R6: Granularity code 11 (mixed): lanes 0 and 1 behave as a half-word pair under the lane 0 enable with data bit 0. Lanes 2 and 3 each behave as byte lanes under their own enables.
- R7: `rd_data[3:0]` returns the lock bits of the register at `rd_addr`. `rd_data[7:4]` is always 0.
- R8: `lock_o[4*i+k]` is the lock bit of lane k of register i. A write is not visible on `lock_o` in the cycle that `wr_en` is high. It appears after the clock edge that samples the write.
- R9: While `wr_en` is 0, no lock bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Lock register write strobe |
| wr_addr | input | ADDR_W | Index of the register written |
| wr_data | input | 8 | Lock data [3:0], lane write enables [7:4] |
| rd_addr | input | ADDR_W | Index of the register read |
| rd_data | output | 8 | Lock bits [3:0], zeros [7:4] |
| gran_cfg | input | 2*NUM_REGS | Granularity code per register, register i in bits [2i+1:2i] |
| lock_o | output | 4*NUM_REGS | Per-lane lock status of every protected word |

## Verification
Directed writes cover the enable patterns that separate the granularities:
- An enable only on lane 1 or lane 3 must do nothing under half-word coding, but must update that lane under byte coding.
- Enables only on lanes 1 to 3 must leave a word-coded register untouched.
- Data that differs between lanes exposes whether the mirroring takes the lower lane's bit or the lane's own bit.

Random writes with random enables, data, addresses and granularity codes are then compared against a per-lane model that picks each lane's controlling lane. This model also catches writes leaking into unselected registers. Reading during the write cycle separates a registered update from a combinational one.

// File: rtl/slb_pkg.sv
package slb_pkg;

  localparam int LANES  = 4;
  localparam int WORD_W = 2 * LANES;

  typedef enum logic [1:0] {
    GR_BYTE = 2'b00,
    GR_HALF = 2'b01,
    GR_WORD = 2'b10,
    GR_MIX  = 2'b11
  } gran_e;

  // Effective per-lane enables after granularity mapping
  function automatic logic [LANES-1:0] map_enable(gran_e g, logic [LANES-1:0] we);
    logic [LANES-1:0] r;
    unique case (g)
      GR_BYTE: r = we;
      GR_HALF: r = {we[2], we[2], we[0], we[0]};
      GR_WORD: r = {LANES{we[0]}};
      default: r = {we[3], we[2], we[0], we[0]};
    endcase
    return r;
  endfunction

  // Effective per-lane data after lower-lane mirroring
  function automatic logic [LANES-1:0] map_data(gran_e g, logic [LANES-1:0] d);
    logic [LANES-1:0] r;
    unique case (g)
      GR_BYTE: r = d;
      GR_HALF: r = {d[2], d[2], d[0], d[0]};
      GR_WORD: r = {LANES{d[0]}};
      default: r = {d[3], d[2], d[0], d[0]};
    endcase
    return r;
  endfunction

  function automatic logic [LANES-1:0] merge_lock(logic [LANES-1:0] old,
                                                  logic [LANES-1:0] en,
                                                  logic [LANES-1:0] d);
    return (old & ~en) | (d & en);
  endfunction

endpackage

// File: rtl/slb_lane_map.sv
module slb_lane_map
  import slb_pkg::*;
(
  input  gran_e            gran,
  input  logic [LANES-1:0] we_raw,
  input  logic [LANES-1:0] dat_raw,
  output logic [LANES-1:0] we_eff,
  output logic [LANES-1:0] dat_eff
);
  always_comb begin
    we_eff  = map_enable(gran, we_raw);
    dat_eff = map_data(gran, dat_raw);
  end
endmodule

// File: rtl/slb_cell.sv
module slb_cell
  import slb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [LANES-1:0] we_eff,
  input  logic [LANES-1:0] dat_eff,
  output logic [LANES-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   lock_q <= '0;
    else if (sel) lock_q <= merge_lock(lock_q, we_eff, dat_eff);
  end
endmodule

// File: rtl/slb_bank.sv
module slb_bank
  import slb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [WORD_W-1:0]         rd_data,
  input  logic [2*NUM_REGS-1:0]     gran_cfg,
  output logic [LANES*NUM_REGS-1:0] lock_o
);

  localparam int TOTAL_LANES = LANES * NUM_REGS;

  // Named internal events, used by the checker
  logic [NUM_REGS-1:0] wr_sel;
  logic [LANES-1:0]    we_in;
  logic [LANES-1:0]    dat_in;

  assign we_in  = wr_data[WORD_W-1:LANES];
  assign dat_in = wr_data[LANES-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [LANES-1:0] en_i;
    logic [LANES-1:0] d_i;
    logic [LANES-1:0] q_i;

    assign wr_sel[i] = wr_en && (wr_addr == IDX);

    slb_lane_map u_map (
      .gran    (gran_e'(gran_cfg[2*i +: 2])),
      .we_raw  (we_in),
      .dat_raw (dat_in),
      .we_eff  (en_i),
      .dat_eff (d_i)
    );

    slb_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (wr_sel[i]),
      .we_eff  (en_i),
      .dat_eff (d_i),
      .lock_q  (q_i)
    );

    assign lock_o[LANES*i +: LANES] = q_i;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(rd_addr) == i) rd_data[LANES-1:0] = lock_o[LANES*i +: LANES];
    end
  end

  logic unused_ok;
  assign unused_ok = ^TOTAL_LANES;

endmodule

// File: rtl/slb_bank_chk.sv
module slb_bank_chk
  import slb_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [WORD_W-1:0]         wr_data,
  input logic [WORD_W-1:0]         rd_data,
  input logic [2*NUM_REGS-1:0]     gran_cfg,
  input logic [LANES*NUM_REGS-1:0] lock_o,
  input logic [NUM_REGS-1:0]       wr_sel
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> lock_o == '0); // R1
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_sel) && (wr_en || wr_sel == '0)); // R2
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[WORD_W-1:LANES] == '0); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(lock_o)); // R9

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    AST_UNSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel[i] |=> $stable(lock_o[LANES*i +: LANES])); // R2
    AST_WORD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] && gran_cfg[2*i +: 2] == 2'b10 && wr_data[4]
      |=> lock_o[LANES*i +: LANES] == {LANES{$past(wr_data[0])}}); // R5
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] && gran_cfg[2*i +: 2] == 2'b10 && !wr_data[4]
      |=> $stable(lock_o[LANES*i +: LANES])); // R5
    AST_HALF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] && gran_cfg[2*i] && wr_data[4]
      |=> lock_o[LANES*i +: 2] == {2{$past(wr_data[0])}}); // R4
    AST_HALF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] && gran_cfg[2*i +: 2] == 2'b01 && !wr_data[6]
      |=> $stable(lock_o[LANES*i+2 +: 2])); // R4
    AST_BYTE_LANE3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] && gran_cfg[2*i +: 2] == 2'b00 && wr_data[7]
      |=> lock_o[LANES*i+3] == $past(wr_data[3])); // R3
  end

endmodule

bind slb_bank slb_bank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .gran_cfg (gran_cfg),
  .lock_o   (lock_o),
  .wr_sel   (wr_sel)
);

// File: tb/sim_slb_bank.sv
module sim_slb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [7:0]     rd_data;
  logic [2*N-1:0] gran_cfg = '0;
  logic [4*N-1:0] lock_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  slb_bank #(.NUM_REGS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .gran_cfg(gran_cfg), .lock_o(lock_o)
  );

  // Lane that governs lane k for a given granularity code
  function automatic int ctl_lane(logic [1:0] g, int k);
    case (g)
      2'b00:   return k;
      2'b01:   return (k / 2) * 2;
      2'b10:   return 0;
      default: return (k < 2) ? 0 : k;
    endcase
  endfunction

  function automatic logic [3:0] next_bits(logic [1:0] g, logic [7:0] w, logic [3:0] old);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      int c = ctl_lane(g, k);
      r[k] = w[4+c] ? w[c] : old[k];
    end
    return r;
  endfunction

  function automatic logic [4*N-1:0] model_vec();
    logic [4*N-1:0] v;
    for (int i = 0; i < N; i++) v[4*i +: 4] = model[i];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(string req, int a, logic [7:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = w; rd_addr = AW'(a);
    #1;
    chk("R8 pre-edge", 32'(lock_o), 32'(model_vec()));
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = next_bits(gran_cfg[2*a +: 2], w, model[a]);
    chk(req, 32'(lock_o), 32'(model_vec()));
    chk("R7", 32'(rd_data), {28'd0, model[a]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < N; i++) model[i] = '0;
    wr_en = 1'b1; wr_data = 8'hFF;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    chk("R1", 32'(lock_o), 32'd0);
    chk("R7 reset", 32'(rd_data), 32'd0);
    rst_n = 1'b1;

    // R3 byte lanes, lane 3 only
    gran_cfg = 8'b11_10_01_00;
    do_write("R3", 0, 8'b1000_1000);
    do_write("R3", 0, 8'b0101_1111);
    // R4 half: lane1/lane3 enables ignored, lane data 1/3 ignored
    do_write("R4", 1, 8'b1010_1111);
    do_write("R4", 1, 8'b0001_1110);
    do_write("R4", 1, 8'b0101_1010);
    // R5 word: upper enables alone do nothing, lane0 fills
    do_write("R5", 2, 8'b1110_1111);
    do_write("R5", 2, 8'b0001_0001);
    do_write("R5", 2, 8'b1111_1110);
    // R6 mixed
    do_write("R6", 3, 8'b0011_0001);
    do_write("R6", 3, 8'b1010_1000);
    do_write("R6", 3, 8'b0100_0110);

    // R9 idle cycles keep state
    repeat (4) @(negedge clk);
    chk("R9", 32'(lock_o), 32'(model_vec()));

    // R2 random writes with random granularity phases
    for (int ph = 0; ph < 8; ph++) begin
      gran_cfg = 8'($urandom);
      for (int n = 0; n < 60; n++) begin
        int a = int'($urandom % N);
        do_write("R2", a, 8'($urandom));
        if ((n % 7) == 0) begin
          @(negedge clk);
          rd_addr = AW'($urandom % N);
          #1;
          chk("R7 read", 32'(rd_data), {28'd0, model[int'(rd_addr)]});
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule